// File: doc/BRIEF.md
# GPIO Pad Controller

A bank of general-purpose pins configured through a word-aligned register bus. Every pin owns two 32-bit configuration words. The first word sets whether the pin is handed to native logic or run as a GPIO, the pin direction, the driven level and the trigger style for downstream interrupt logic. This word also returns the synchronised input level. The second word gates input sensing and carries a weak-pull code, which goes out to the pad cell.

A read-only ownership bitmap comes from a parameter at elaboration. It tells software which pins firmware keeps for itself. The controller drives pad output and output-enable, and samples pad inputs through a two-flop synchroniser. It exports the trigger and pull fields untouched, for neighbouring blocks to act on.

Reads are combinational from the byte offset on `addr_i`. Writes take effect on the clock edge where `we_i` is high.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, each pin's first word reads 0x0000_0004 and its second word reads 0x0000_0004. This means native function, direction input, output level 0, trigger bits 0, sensing disabled and pull code 0.
- R2: Pin n's first word sits at byte offset 0x100+8n and its second word at 0x104+8n. Writable bits in the first word are 31 (output level), 4 (level trigger), 3 (trigger invert), 2 (direction, 1 = input) and 0 (1 = GPIO). Writable bits in the second word are 2 (sensing disable) and 1:0 (pull). All other bits read 0, and a write touches only the addressed pin.
- R3: Bit 30 of the first word is read-only and returns the input level. Writing it has no effect.
- R4: While bit 2 of the second word is 1, bit 30 of the first word and `in_lvl_o` read 0.
- R5: A change on `pad_i` reaches bit 30 and `in_lvl_o` after exactly two rising clock edges.
- R6: `pad_oe_o` is 1 only when bit 0 is 1 and bit 2 is 0 in the first word. `pad_o` follows bit 31. Both change on the write edge.
- R7: `gpio_mode_o`, `trig_lvl_o` and `trig_inv_o` follow bits 0, 4 and 3 of the first word. `pull_o[2n+1:2n]` follows bits 1:0 of pin n's second word.
- R8: The word at offset 4g returns ownership bits for pins 32g to 32g+31, with bit b standing for pin 32g+b. The values come from `OWN_MAP`, where 0 means the pin is reserved for firmware. Bits past the last pin read 0, and writes to these words are ignored.
- R9: Offsets that are not multiples of 4, the gap between the bitmap and 0x100, and offsets at or beyond 0x100+8·NUM_PINS all read 0. Writes to them change nothing.
- R10: `rdata_o` reflects the current `addr_i` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pad_i | input | NUM_PINS | Raw pad input levels |
| pad_o | output | NUM_PINS | Pad output levels |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| gpio_mode_o | output | NUM_PINS | 1 = pin run as GPIO, 0 = native |
| in_lvl_o | output | NUM_PINS | Synchronised, sense-gated input level |
| trig_lvl_o | output | NUM_PINS | Trigger type per pin, 1 = level |
| trig_inv_o | output | NUM_PINS | Trigger invert per pin |
| pull_o | output | 2*NUM_PINS | Weak-pull code, two bits per pin |

## Verification
The bound checker covers several behaviours on every cycle, for every pin:
- a write to a first word sets `pad_o` and `pad_oe_o` on the next cycle as the written bits dictate;
- a write that disables sensing forces `in_lvl_o` low;
- a high `in_lvl_o` always matches the pad level two edges earlier;
- the first bitmap word always returns the parameter;
- every unmapped offset reads zero.

Write isolation between neighbouring pins, the read-only input bit, the exact two-edge latency in both directions, reset values and field readback are shown only by the bench's scenarios.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  localparam int unsigned CFG_BASE = 32'h100;

  typedef struct packed {
    logic out_lvl;
    logic trig_lvl;
    logic trig_inv;
    logic dir_in;
    logic gpio_sel;
  } ctl_t;

  typedef struct packed {
    logic       sense_dis;
    logic [1:0] pull;
  } padcfg_t;

  localparam ctl_t CTL_RST = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                               dir_in: 1'b1, gpio_sel: 1'b0};
  localparam padcfg_t PADCFG_RST = '{sense_dis: 1'b1, pull: 2'b00};

  function automatic logic [31:0] ctl_word(ctl_t c, logic in_lvl);
    logic [31:0] w;
    w     = '0;
    w[31] = c.out_lvl;
    w[30] = in_lvl;
    w[4]  = c.trig_lvl;
    w[3]  = c.trig_inv;
    w[2]  = c.dir_in;
    w[0]  = c.gpio_sel;
    return w;
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12,
  parameter int NGRP     = 3,
  parameter int PIN_W    = 7,
  parameter int GRP_W    = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              own_hit_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic              cfg_hit_o,
  output logic              cfg_hi_o,
  output logic [PIN_W-1:0]  pin_o
);
  localparam int IDX_W = ADDR_W - 3;

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic              in_cfg;

  assign rel    = addr_i - ADDR_W'(CFG_BASE);
  assign idx    = rel[ADDR_W-1:3];
  assign in_cfg = addr_i >= ADDR_W'(CFG_BASE);

  assign cfg_hit_o = in_cfg && (rel[1:0] == 2'b00) && (idx < IDX_W'(NUM_PINS));
  assign cfg_hi_o  = rel[2];
  assign pin_o     = PIN_W'(idx);

  assign own_hit_o = (addr_i < ADDR_W'(4 * NGRP)) && (addr_i[1:0] == 2'b00);
  assign grp_o     = GRP_W'(addr_i[ADDR_W-1:2]);
endmodule

// File: rtl/gpio_pad_pin_regs.sv
module gpio_pad_pin_regs
  import gpio_pad_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_ctl_i,
  input  logic    we_pad_i,
  input  ctl_t    ctl_d_i,
  input  padcfg_t pad_d_i,
  output ctl_t    ctl_o,
  output padcfg_t pad_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= CTL_RST;
      pad_o <= PADCFG_RST;
    end else begin
      if (we_ctl_i) ctl_o <= ctl_d_i;
      if (we_pad_i) pad_o <= pad_d_i;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int                  NUM_PINS = 94,
  parameter int                  ADDR_W   = 12,
  parameter logic [NUM_PINS-1:0] OWN_MAP  = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pad_i,
  output logic [NUM_PINS-1:0]   pad_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   gpio_mode_o,
  output logic [NUM_PINS-1:0]   in_lvl_o,
  output logic [NUM_PINS-1:0]   trig_lvl_o,
  output logic [NUM_PINS-1:0]   trig_inv_o,
  output logic [2*NUM_PINS-1:0] pull_o
);
  localparam int NGRP  = (NUM_PINS + 31) / 32;
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int OWN_W = NGRP * 32;
  localparam logic [OWN_W-1:0] OWN_PAD = OWN_W'(OWN_MAP);

  logic             own_hit, cfg_hit, cfg_hi;
  logic [GRP_W-1:0] grp;
  logic [PIN_W-1:0] pin;

  gpio_pad_decode #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .NGRP(NGRP),
    .PIN_W(PIN_W), .GRP_W(GRP_W)
  ) u_decode (
    .addr_i   (addr_i),
    .own_hit_o(own_hit),
    .grp_o    (grp),
    .cfg_hit_o(cfg_hit),
    .cfg_hi_o (cfg_hi),
    .pin_o    (pin)
  );

  ctl_t    wr_ctl;
  padcfg_t wr_pad;
  logic    unused_wdata;

  assign wr_ctl = '{out_lvl: wdata_i[31], trig_lvl: wdata_i[4], trig_inv: wdata_i[3],
                    dir_in: wdata_i[2], gpio_sel: wdata_i[0]};
  assign wr_pad = '{sense_dis: wdata_i[2], pull: wdata_i[1:0]};
  assign unused_wdata = ^wdata_i[30:5];

  ctl_t                ctl_q [NUM_PINS];
  padcfg_t             padc_q[NUM_PINS];
  logic [NUM_PINS-1:0] sync_in, in_vis;

  gpio_pad_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync_in)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic sel;
    assign sel = we_i && cfg_hit && (pin == PIN_W'(k));

    gpio_pad_pin_regs u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_ctl_i(sel && !cfg_hi),
      .we_pad_i(sel && cfg_hi),
      .ctl_d_i (wr_ctl),
      .pad_d_i (wr_pad),
      .ctl_o   (ctl_q[k]),
      .pad_o   (padc_q[k])
    );

    // sensing off forces the level low, both at the port and on readback
    assign in_vis[k]         = sync_in[k] & ~padc_q[k].sense_dis;
    assign pad_o[k]          = ctl_q[k].out_lvl;
    assign pad_oe_o[k]       = ctl_q[k].gpio_sel & ~ctl_q[k].dir_in;
    assign gpio_mode_o[k]    = ctl_q[k].gpio_sel;
    assign trig_lvl_o[k]     = ctl_q[k].trig_lvl;
    assign trig_inv_o[k]     = ctl_q[k].trig_inv;
    assign pull_o[2*k +: 2]  = padc_q[k].pull;
  end

  assign in_lvl_o = in_vis;

  always_comb begin
    rdata_o = '0;
    if (own_hit) begin
      rdata_o = OWN_PAD[32*grp +: 32];
    end else if (cfg_hit) begin
      if (cfg_hi) rdata_o = {29'b0, padc_q[pin]};
      else        rdata_o = ctl_word(ctl_q[pin], in_vis[pin]);
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int                  NUM_PINS = 94,
  parameter int                  ADDR_W   = 12,
  parameter logic [NUM_PINS-1:0] OWN_MAP  = '1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  we_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_PINS-1:0]   pad_i,
  input logic [NUM_PINS-1:0]   pad_o,
  input logic [NUM_PINS-1:0]   pad_oe_o,
  input logic [NUM_PINS-1:0]   in_lvl_o
);
  localparam int NGRP  = (NUM_PINS + 31) / 32;
  localparam int OWN_W = NGRP * 32;
  localparam logic [OWN_W-1:0] OWN_PAD = OWN_W'(OWN_MAP);

  logic [1:0] cyc_q;
  logic       cyc_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end
  assign cyc_ok = cyc_q >= 2'd2;

  logic mapped;
  always_comb begin
    int a;
    a = int'(addr_i);
    if (addr_i[1:0] != 2'b00)                          mapped = 1'b0;
    else if (a < 4 * NGRP)                             mapped = 1'b1;
    else if (a >= 'h100 && a < 'h100 + 8 * NUM_PINS)   mapped = 1'b1;
    else                                               mapped = 1'b0;
  end

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == 32'h0);

  p_own_word0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> rdata_o == OWN_PAD[31:0]);

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(32'h100 + 8 * k);
    localparam logic [ADDR_W-1:0] A_PAD = ADDR_W'(32'h104 + 8 * k);

    p_oe_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_CTL) |=> pad_oe_o[k] == ($past(wdata_i[0]) && !$past(wdata_i[2])));

    p_out_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_CTL) |=> pad_o[k] == $past(wdata_i[31]));

    p_sense_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_PAD && wdata_i[2]) |=> !in_lvl_o[k]);

    p_sync_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_ok && in_lvl_o[k]) |-> $past(pad_i[k], 2));
  end
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .OWN_MAP(OWN_MAP)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_i   (pad_i),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o),
  .in_lvl_o(in_lvl_o)
);

// File: tb/gpio_pad_ctrl_bench.sv
module gpio_pad_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 94;
  localparam int AW = 12;
  localparam logic [N-1:0] OWN = {30'h3ABC_DEF1, 32'hF0F0_1234, 32'h8000_0001};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            we = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [N-1:0]    pad_in = '0;
  logic [N-1:0]    pad_out, pad_oe, gmode, in_lvl, tlvl, tinv;
  logic [2*N-1:0]  pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_ctrl #(.NUM_PINS(N), .ADDR_W(AW), .OWN_MAP(OWN)) u_gpio_pad_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe),
    .gpio_mode_o(gmode), .in_lvl_o(in_lvl), .trig_lvl_o(tlvl),
    .trig_inv_o(tinv), .pull_o(pull)
  );

  // probe kinds: 0 rdata, 1 oe, 2 out, 3 in_lvl, 4 mode, 5 trig_lvl, 6 trig_inv, 7 pull
  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit summarized = 1'b0;

  function automatic logic [31:0] probe(int kind, int idx);
    case (kind)
      0: return rdata;
      1: return {31'b0, pad_oe[idx]};
      2: return {31'b0, pad_out[idx]};
      3: return {31'b0, in_lvl[idx]};
      4: return {31'b0, gmode[idx]};
      5: return {31'b0, tlvl[idx]};
      6: return {31'b0, tinv[idx]};
      default: return {30'b0, pull[2*idx +: 2]};
    endcase
  endfunction

  // monitor: compares every queued item in the cycle it was pushed
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = probe(it.kind, it.idx);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                   it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic exp_rd(input int a, input logic [31:0] e, input string r);
    item_t it;
    @(negedge clk);
    addr = AW'(a); we = 1'b0;
    it = '{kind: 0, idx: 0, exp: e, req: r};
    q.push_back(it);
  endtask

  task automatic exp_port(input int kind, input int idx, input logic [31:0] e, input string r);
    item_t it;
    @(negedge clk);
    it = '{kind: kind, idx: idx, exp: e, req: r};
    q.push_back(it);
  endtask

  function automatic int a_ctl(int p); return 'h100 + 8 * p; endfunction
  function automatic int a_pad(int p); return 'h104 + 8 * p; endfunction

  task automatic summary();
    if (!summarized) begin
      summarized = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    exp_rd(a_ctl(0), 32'h0000_0004, "R1");
    exp_rd(a_pad(0), 32'h0000_0004, "R1");
    exp_rd(a_ctl(93), 32'h0000_0004, "R1");
    exp_port(1, 0, 32'h0, "R1");
    exp_port(4, 0, 32'h0, "R1");

    // R2: field masks and isolation
    wr(a_ctl(5), 32'hFFFF_FFFF);
    exp_rd(a_ctl(5), 32'h8000_001D, "R2");
    wr(a_pad(5), 32'hFFFF_FFFF);
    exp_rd(a_pad(5), 32'h0000_0007, "R2");
    exp_rd(a_ctl(4), 32'h0000_0004, "R2");
    exp_rd(a_ctl(6), 32'h0000_0004, "R2");
    exp_rd(a_pad(6), 32'h0000_0004, "R2");

    // R7: exported configuration bits
    exp_port(4, 5, 32'h1, "R7");
    exp_port(5, 5, 32'h1, "R7");
    exp_port(6, 5, 32'h1, "R7");
    exp_port(7, 5, 32'h3, "R7");
    exp_port(7, 4, 32'h0, "R7");

    // R6: output enable gating
    exp_port(1, 5, 32'h0, "R6");
    wr(a_ctl(5), 32'h8000_0001);
    exp_port(1, 5, 32'h1, "R6");
    exp_port(2, 5, 32'h1, "R6");
    wr(a_ctl(5), 32'h8000_0000);
    exp_port(1, 5, 32'h0, "R6");
    wr(a_ctl(5), 32'h0000_0001);
    exp_port(1, 5, 32'h1, "R6");
    exp_port(2, 5, 32'h0, "R6");

    // R5: two-edge synchroniser latency, rising and falling
    wr(a_pad(93), 32'h0);
    @(negedge clk); pad_in[93] = 1'b1;
    exp_port(3, 93, 32'h0, "R5");
    exp_port(3, 93, 32'h1, "R5");
    exp_rd(a_ctl(93), 32'h4000_0004, "R5");
    @(negedge clk); pad_in[93] = 1'b0;
    exp_port(3, 93, 32'h1, "R5");
    exp_port(3, 93, 32'h0, "R5");

    // R4: sensing disable forces zero
    @(negedge clk); pad_in[93] = 1'b1;
    repeat (3) @(negedge clk);
    exp_port(3, 93, 32'h1, "R4");
    wr(a_pad(93), 32'h0000_0004);
    exp_port(3, 93, 32'h0, "R4");
    exp_rd(a_ctl(93), 32'h0000_0004, "R4");

    // R3: input bit is read-only
    wr(a_pad(93), 32'h0);
    @(negedge clk); pad_in[93] = 1'b0;
    repeat (3) @(negedge clk);
    wr(a_ctl(93), 32'h4000_0004);
    exp_rd(a_ctl(93), 32'h0000_0004, "R3");

    // R8: ownership bitmap
    exp_rd('h0, 32'h8000_0001, "R8");
    exp_rd('h4, 32'hF0F0_1234, "R8");
    exp_rd('h8, 32'h3ABC_DEF1, "R8");
    wr('h0, 32'h0);
    exp_rd('h0, 32'h8000_0001, "R8");

    // R9: unmapped offsets
    exp_rd('hC, 32'h0, "R9");
    exp_rd('h50, 32'h0, "R9");
    exp_rd('h102, 32'h0, "R9");
    exp_rd('h3F0, 32'h0, "R9");
    exp_rd('h3F4, 32'h0, "R9");
    wr('h3F0, 32'hFFFF_FFFF);
    wr('h102, 32'hFFFF_FFFF);
    exp_rd(a_ctl(0), 32'h0000_0004, "R9");
    exp_rd(a_ctl(93), 32'h0000_0004, "R9");

    // R10: back-to-back addresses, each answered in its own cycle
    exp_rd(a_pad(5), 32'h0000_0007, "R10");
    exp_rd(a_ctl(5), 32'h0000_0001, "R10");
    exp_rd('h4, 32'hF0F0_1234, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule